// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a simple synchronous request port to an external asynchronous static RAM of 512K words of 16 bits. The host presents a byte address, write data, two byte strobes and a read/write flag under a valid/ready handshake. The controller runs one access at a time on a separate address bus and data bus. It drives one chip select per channel, an output enable, a write enable and two active-low byte-lane strobes. It answers every accepted request with a single-cycle response that carries either read data or an error flag.

Each access has two timed phases. The first is an address-setup phase whose length is set by a configuration input. The second is a data phase, also set by a configuration input, during which output enable (reads) or write enable (writes) is held low. An integrator reaches the 55 ns cycle, 55 ns access and 40 ns write-pulse limits of the memory by choosing these two lengths for the clock in use. Both fields come out of reset as 0 and 3 at the register stage that feeds them. A 256 MB host window is split into four 64 MB channels, each with its own chip select. A per-channel enable gates every access to that channel. A write-permit input gates every write.

The data bus is split into an output, an output-enable and an input, so that the pad cell sits outside this block.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While and after a synchronous reset the controller is idle: `req_ready`=1, all `mem_ce_n` bits 1, `mem_oe_n`=1, `mem_we_n`=1, `mem_bl_n`=2'b11, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: A request is valid only when host address bits [31:28] equal 4'h6. Bits [27:26] pick the channel, and only `mem_ce_n[channel]` goes low during the access. `mem_addr` carries host address bits [19:1]. Bit 0 is ignored.
- R3: A read accepted on edge E holds its chip select low with `mem_oe_n` high for `cfg_addset`+1 cycles. It then holds `mem_oe_n` low for `cfg_datast`+1 cycles and samples `mem_dq_i` on the last of them. In the cycle after that, `rsp_valid`=1, `rsp_err`=0 and `rsp_rdata` shows the sampled word, with all strobes released.
- R4: A write follows the same setup timing and then holds `mem_we_n` low for `cfg_datast`+1 cycles, with `mem_dq_oe`=1 and `mem_dq_o` equal to the write data. In the single cycle after `mem_we_n` rises, `mem_dq_oe` stays 1, chip select stays low and the response (`rsp_valid`=1, `rsp_err`=0) is given. After that the bus is released.
- R5: While chip select is low, `mem_bl_n` equals the inverse of `req_be`. Bit 0 is the low byte (`mem_dq[7:0]`) and bit 1 is the high byte, so a write with one strobe leaves the other byte of the word unchanged.
- R6: When `cfg_wr_en`=0, a write is answered one cycle after acceptance with `rsp_valid`=1 and `rsp_err`=1. No chip select or write strobe is asserted and the memory is not changed. Reads are not affected.
- R7: When `cfg_bank_en[channel]`=0, any request to that channel is answered with the error response one cycle after acceptance, and no strobe is asserted.
- R8: A request outside the window, or with any of host address bits [25:20] set (beyond the 1 MB device in its channel), is answered with the error response and no strobe. The top word of each channel is still reachable.
- R9: `req_ready` is 1 only when the controller is idle. A request held valid during an access is not taken again.
- R10: `mem_oe_n` and `mem_we_n` are never low together, and at most one chip select is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bank_en | input | 4 | Per-channel access enable |
| cfg_wr_en | input | 1 | Write permit; writes are refused when 0 |
| cfg_addset | input | 4 | Address-setup length minus one, in cycles |
| cfg_datast | input | 8 | Data-phase length minus one, in cycles |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte strobes, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 19 | Memory word address |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data from memory |
| mem_ce_n | output | 4 | Active-low chip select per channel |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bl_n | output | 2 | Active-low byte-lane strobes |

## Verification
Counting from the accepting edge, a good access spends cycles 0 to `cfg_addset` in setup and the following `cfg_datast`+1 cycles in the data phase. Its response falls in cycle `cfg_addset`+`cfg_datast`+2, and a refused request answers in cycle 0. The bench's reference model rebuilds this schedule for every request from the configuration alone. It compares every port on the falling edge of each of those cycles and also on each idle cycle between requests, so any cycle off by one in a phase or the response shows up as a mismatch in that exact cycle. Read data is compared with a separate expected memory that the model updates byte-wise. The bench's RAM model drives a marker value whenever output enable is high, so a sample taken outside the data phase is also caught.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the asynchronous SRAM controller.
// Assumes nothing; holds only the sequencer state encoding.
package sram_ctrl_pkg;

    // Access sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_DATA   = 3'd2,
        ST_RDRSP  = 3'd3,
        ST_WRHOLD = 3'd4,
        ST_ERR    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/sram_addr_decode.sv
`timescale 1ns/1ps
// Module: sram_addr_decode
// Splits a host byte address into channel and word address and decides
// whether the request may reach the memory (window tag, device range,
// per-channel enable and write permit). Purely combinational.
// Assumes the channel field lies directly above the channel span.
module sram_addr_decode #(
    parameter int HADDR_W      = 32,
    parameter int MEM_AW       = 19,
    parameter int CH_LOG2      = 2,
    parameter int CH_SPAN_LOG2 = 26,
    parameter int WIN_TAG      = 6
) (
    input  logic [HADDR_W-1:0]        host_addr,
    input  logic                      is_write,
    input  logic [(1<<CH_LOG2)-1:0]   chan_en,
    input  logic                      write_permit,
    output logic                      hit,
    output logic [CH_LOG2-1:0]        chan,
    output logic [MEM_AW-1:0]         word
);
    localparam int TAG_W   = HADDR_W - CH_SPAN_LOG2 - CH_LOG2;
    localparam int DEV_TOP = MEM_AW + 1;

    logic in_window;
    logic in_device;
    logic unused_lsb;

    // Window tag compare on the top address bits.
    assign in_window = host_addr[HADDR_W-1 -: TAG_W] == TAG_W'(WIN_TAG);

    // Bits between the device size and the channel span must be zero.
    generate
        if (CH_SPAN_LOG2 > DEV_TOP) begin : g_range
            assign in_device = host_addr[CH_SPAN_LOG2-1:DEV_TOP] == '0;
        end else begin : g_full
            assign in_device = 1'b1;
        end
    endgenerate

    // Field extraction and final permit.
    assign chan       = host_addr[CH_SPAN_LOG2 +: CH_LOG2];
    assign word       = host_addr[MEM_AW:1];
    assign unused_lsb = host_addr[0];
    assign hit        = in_window && in_device && chan_en[chan] &&
                        (!is_write || write_permit);
endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Module: sram_phase_timer
// Down-counter that times one access phase. Loaded with (length-1);
// 'last' is high in the final cycle of the phase.
// Assumes the loader reloads it in the last cycle of each phase.
module sram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count down toward zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/sram_access_seq.sv
`timescale 1ns/1ps
// Module: sram_access_seq
// Runs one memory access at a time: address setup, data phase, then a
// one-cycle response (with bus hold for writes) or an error response.
// Assumes the decoder result is valid while req_valid is high in idle and
// that configuration inputs only change while idle.
module sram_access_seq
    import sram_ctrl_pkg::*;
#(
    parameter int MEM_AW  = 19,
    parameter int DATA_W  = 16,
    parameter int CH_LOG2 = 2,
    parameter int AS_W    = 4,
    parameter int DS_W    = 8,
    parameter int CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [DATA_W/8-1:0]       req_be,
    input  logic                      dec_hit,
    input  logic [CH_LOG2-1:0]        dec_chan,
    input  logic [MEM_AW-1:0]         dec_word,
    input  logic [AS_W-1:0]           cfg_addset,
    input  logic [DS_W-1:0]           cfg_datast,
    output logic                      tmr_load,
    output logic [CNT_W-1:0]          tmr_val,
    input  logic                      tmr_last,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [MEM_AW-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_dq_o,
    output logic                      mem_dq_oe,
    input  logic [DATA_W-1:0]         mem_dq_i,
    output logic [(1<<CH_LOG2)-1:0]   mem_ce_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [DATA_W/8-1:0]       mem_bl_n
);
    localparam int CH_N = 1 << CH_LOG2;
    localparam int BL_W = DATA_W / 8;

    seq_state_t          state;
    logic                lat_write;
    logic [CH_LOG2-1:0]  lat_chan;
    logic [MEM_AW-1:0]   lat_word;
    logic [DATA_W-1:0]   lat_wdata;
    logic [BL_W-1:0]     lat_be;
    logic [DATA_W-1:0]   rdata_q;
    logic                accept;
    logic                ce_act;
    logic                in_data;

    assign accept = (state == ST_IDLE) && req_valid;

    // State walk and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_write <= 1'b0;
            lat_chan  <= '0;
            lat_word  <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
            rdata_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    lat_write <= req_write;
                    lat_chan  <= dec_chan;
                    lat_word  <= dec_word;
                    lat_wdata <= req_wdata;
                    lat_be    <= req_be;
                    state     <= dec_hit ? ST_SETUP : ST_ERR;
                end
                ST_SETUP: if (tmr_last) state <= ST_DATA;
                ST_DATA: if (tmr_last) begin
                    if (lat_write) begin
                        state <= ST_WRHOLD;
                    end else begin
                        rdata_q <= mem_dq_i;
                        state   <= ST_RDRSP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase timer loading: setup length on accept, data length after setup.
    assign tmr_load = (accept && dec_hit) || (state == ST_SETUP && tmr_last);
    assign tmr_val  = (state == ST_IDLE) ? CNT_W'(cfg_addset) : CNT_W'(cfg_datast);

    // Strobe activity derived from the state.
    assign ce_act  = (state == ST_SETUP) || (state == ST_DATA) || (state == ST_WRHOLD);
    assign in_data = (state == ST_DATA);

    // One chip select per channel.
    generate
        for (genvar c = 0; c < CH_N; c++) begin : g_ce
            assign mem_ce_n[c] = !(ce_act && (lat_chan == CH_LOG2'(c)));
        end
    endgenerate

    // Memory-side outputs.
    assign mem_addr  = lat_word;
    assign mem_dq_o  = lat_wdata;
    assign mem_oe_n  = !(in_data && !lat_write);
    assign mem_we_n  = !(in_data && lat_write);
    assign mem_bl_n  = ce_act ? ~lat_be : '1;
    assign mem_dq_oe = lat_write && (in_data || state == ST_WRHOLD);

    // Host-side outputs.
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RDRSP) || (state == ST_WRHOLD) || (state == ST_ERR);
    assign rsp_err   = (state == ST_ERR);
    assign rsp_rdata = rdata_q;

    // R4
    we_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);
    // R4
    bus_hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && rsp_valid && !rsp_err));
    // R3
    oe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_ce_n) == mem_ce_n && mem_ce_n != '1));
    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n || mem_we_n));
    // R10
    one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);
    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n != '1) |-> !req_ready);
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
// Module: sram_bus_ctrl (top)
// Bridges a valid/ready host port to an external asynchronous 16-bit SRAM
// across four chip-select channels with programmable phase lengths.
// Assumes the data pads (tristate) are outside this block.
module sram_bus_ctrl #(
    parameter int HADDR_W      = 32,
    parameter int MEM_AW       = 19,
    parameter int DATA_W       = 16,
    parameter int CH_LOG2      = 2,
    parameter int CH_SPAN_LOG2 = 26,
    parameter int WIN_TAG      = 6,
    parameter int AS_W         = 4,
    parameter int DS_W         = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(1<<CH_LOG2)-1:0]   cfg_bank_en,
    input  logic                      cfg_wr_en,
    input  logic [AS_W-1:0]           cfg_addset,
    input  logic [DS_W-1:0]           cfg_datast,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [HADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [DATA_W/8-1:0]       req_be,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [MEM_AW-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_dq_o,
    output logic                      mem_dq_oe,
    input  logic [DATA_W-1:0]         mem_dq_i,
    output logic [(1<<CH_LOG2)-1:0]   mem_ce_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [DATA_W/8-1:0]       mem_bl_n
);
    localparam int CNT_W = (AS_W > DS_W) ? AS_W : DS_W;

    logic               dec_hit;
    logic [CH_LOG2-1:0] dec_chan;
    logic [MEM_AW-1:0]  dec_word;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_last;

    sram_addr_decode #(
        .HADDR_W(HADDR_W), .MEM_AW(MEM_AW), .CH_LOG2(CH_LOG2),
        .CH_SPAN_LOG2(CH_SPAN_LOG2), .WIN_TAG(WIN_TAG)
    ) i_decode (
        .host_addr(req_addr), .is_write(req_write), .chan_en(cfg_bank_en),
        .write_permit(cfg_wr_en), .hit(dec_hit), .chan(dec_chan), .word(dec_word)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    sram_access_seq #(
        .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CH_LOG2(CH_LOG2),
        .AS_W(AS_W), .DS_W(DS_W), .CNT_W(CNT_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wdata(req_wdata), .req_be(req_be),
        .dec_hit(dec_hit), .dec_chan(dec_chan), .dec_word(dec_word),
        .cfg_addset(cfg_addset), .cfg_datast(cfg_datast),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_last(tmr_last),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n)
    );

    // R8
    refused_req_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dec_hit) |=> (rsp_valid && rsp_err && mem_ce_n == '1));
    // R6
    no_write_without_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !cfg_wr_en) |=> (mem_we_n && rsp_err));
endmodule

// File: tb/test_sram_bus_ctrl.sv
`timescale 1ns/1ps
module test_sram_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_bank_en;
    logic        cfg_wr_en;
    logic [3:0]  cfg_addset;
    logic [7:0]  cfg_datast;
    logic        req_valid, req_write;
    logic [31:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        req_ready, rsp_valid, rsp_err;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [18:0] mem_addr;
    logic        mem_dq_oe, mem_oe_n, mem_we_n;
    logic [3:0]  mem_ce_n;
    logic [1:0]  mem_bl_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [15:0] sram    [0:1023];
    logic [15:0] exp_mem [0:1023];

    always #2.5 clk = ~clk;

    sram_bus_ctrl i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_bank_en(cfg_bank_en), .cfg_wr_en(cfg_wr_en),
        .cfg_addset(cfg_addset), .cfg_datast(cfg_datast),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n)
    );

    // Selected channel of the RAM model (0..3), or 4 when none.
    function automatic int sel_ch();
        int s = 4;
        for (int c = 0; c < 4; c++) if (!mem_ce_n[c]) s = c;
        return s;
    endfunction

    // RAM model read path: marker value unless output enable is low.
    always_comb begin
        int s;
        s = sel_ch();
        if (!mem_oe_n && s < 4) mem_dq_i = sram[{s[1:0], mem_addr[7:0]}];
        else                    mem_dq_i = 16'h0BAD;
    end

    // RAM model write path, sampled away from the clock edge.
    always @(negedge clk) begin
        int s;
        s = sel_ch();
        if (!mem_we_n && s < 4 && mem_dq_oe) begin
            if (!mem_bl_n[0]) sram[{s[1:0], mem_addr[7:0]}][7:0]  = mem_dq_o[7:0];
            if (!mem_bl_n[1]) sram[{s[1:0], mem_addr[7:0]}][15:8] = mem_dq_o[15:8];
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog (R1..all): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // Compare all ports against the model's expectation for this cycle.
    task automatic cmp(string tag, logic [11:0] exp_ctl,
                       bit ca, logic [18:0] ea, bit cd, logic [15:0] ed,
                       bit cr, logic [15:0] er);
        logic [11:0] act_ctl;
        bit ok;
        act_ctl = {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_bl_n,
                   mem_dq_oe, rsp_valid, rsp_err};
        ok = (act_ctl == exp_ctl) && (!ca || mem_addr == ea) &&
             (!cd || mem_dq_o == ed) && (!cr || rsp_rdata == er);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual ctl=%h addr=%h dq=%h rd=%h expected ctl=%h addr=%h dq=%h rd=%h",
                     tag, act_ctl, mem_addr, mem_dq_o, rsp_rdata, exp_ctl, ea, ed, er);
        end
        // R10 strobe exclusivity
        n_chk++;
        if (!(mem_oe_n || mem_we_n) || $countones(~mem_ce_n) > 1) begin
            n_bad++;
            $display("FAIL R10: actual oe=%b we=%b ce=%b expected exclusive",
                     mem_oe_n, mem_we_n, mem_ce_n);
        end
    endtask

    function automatic logic [11:0] idle_ctl();
        return {1'b1, 4'hF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0};
    endfunction

    // One request plus its full cycle-by-cycle expected schedule.
    task automatic acc(string tag, bit wr, logic [31:0] a, logic [15:0] wd,
                       logic [1:0] be, bit hold);
        logic [1:0]  ch;
        logic [18:0] wa;
        logic [9:0]  idx;
        bit okr;
        int na, nd, last;
        ch  = a[27:26];
        wa  = a[19:1];
        idx = {ch, wa[7:0]};
        okr = (a[31:28] == 4'h6) && (a[25:20] == 6'd0) && cfg_bank_en[ch] &&
              (!wr || cfg_wr_en);
        na  = cfg_addset;
        nd  = cfg_datast;
        last = okr ? na + nd + 2 : 0;
        @(negedge clk);
        cmp({tag, " idle"}, idle_ctl(), 0, 0, 0, 0, 0, 0);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        for (int k = 0; k <= last; k++) begin
            bit st, dt, fn, cea;
            logic [3:0] ce;
            @(negedge clk);
            if (!hold || k == last) req_valid = 0;
            if (!okr) begin
                cmp({tag, " err"}, {1'b0, 4'hF, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
                    0, 0, 0, 0, 0, 0);
            end else begin
                st  = (k <= na);
                dt  = (k > na) && (k <= na + nd + 1);
                fn  = (k == last);
                cea = st || dt || (fn && wr);
                ce  = cea ? ~(4'b0001 << ch) : 4'hF;
                cmp(tag, {1'b0, ce, !(dt && !wr), !(dt && wr), cea ? ~be : 2'b11,
                          wr && (dt || fn), fn, 1'b0},
                    cea, wa, wr && (dt || fn), wd, fn && !wr, exp_mem[idx]);
            end
        end
        if (okr && wr) begin
            if (be[0]) exp_mem[idx][7:0]  = wd[7:0];
            if (be[1]) exp_mem[idx][15:8] = wd[15:8];
        end
    endtask

    function automatic logic [31:0] ha(int ch, int w);
        return 32'h6000_0000 | (32'(ch) << 26) | (32'(w) << 1);
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin
            sram[i]    = 16'(i * 16'h0101) ^ 16'h5A5A;
            exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
        end
        rst_n = 0; cfg_bank_en = 4'hF; cfg_wr_en = 1; cfg_addset = 0; cfg_datast = 3;
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_be = 0;
        repeat (3) @(negedge clk);
        cmp("R1 in reset", idle_ctl(), 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        cmp("R1 after reset", idle_ctl(), 0, 0, 0, 0, 0, 0);

        // R4 R2 R3: default phase lengths, channel 0
        acc("R4 write ch0", 1, ha(0, 5), 16'h1234, 2'b11, 0);
        acc("R3 read ch0", 0, ha(0, 5), 0, 2'b11, 0);
        // R3 R4 with other phase lengths on channel 1
        cfg_addset = 2; cfg_datast = 1;
        acc("R4 write ch1", 1, ha(1, 8'h7F), 16'hBEEF, 2'b11, 0);
        acc("R3 read ch1", 0, ha(1, 8'h7F), 0, 2'b11, 0);
        // R2 remaining channels, short phases
        cfg_addset = 1; cfg_datast = 0;
        acc("R2 write ch2", 1, ha(2, 3), 16'hC0DE, 2'b11, 0);
        acc("R2 write ch3", 1, ha(3, 3), 16'h0F0F, 2'b11, 0);
        acc("R2 read ch2", 0, ha(2, 3), 0, 2'b11, 0);
        acc("R2 read ch3", 0, ha(3, 3), 0, 2'b11, 0);
        acc("R2 odd byte addr", 0, ha(3, 3) | 32'h1, 0, 2'b11, 0);
        // R5 byte lanes
        cfg_addset = 0; cfg_datast = 3;
        acc("R5 full", 1, ha(0, 9), 16'hAAAA, 2'b11, 0);
        acc("R5 low", 1, ha(0, 9), 16'h1155, 2'b01, 0);
        acc("R5 high", 1, ha(0, 9), 16'h33CC, 2'b10, 0);
        acc("R5 read", 0, ha(0, 9), 0, 2'b11, 0);
        // R6 write permit clear
        cfg_wr_en = 0;
        acc("R6 blocked write", 1, ha(0, 9), 16'hFFFF, 2'b11, 0);
        acc("R6 read unchanged", 0, ha(0, 9), 0, 2'b11, 0);
        cfg_wr_en = 1;
        // R7 channel disabled
        cfg_bank_en = 4'b0111;
        acc("R7 read off ch3", 0, ha(3, 3), 0, 2'b11, 0);
        acc("R7 write off ch3", 1, ha(3, 3), 16'h7777, 2'b11, 0);
        cfg_bank_en = 4'hF;
        acc("R7 ch3 intact", 0, ha(3, 3), 0, 2'b11, 0);
        // R8 range
        acc("R8 above window", 0, 32'h7000_0000, 0, 2'b11, 0);
        acc("R8 below window", 1, 32'h5FFF_FFFE, 16'h1, 2'b11, 0);
        acc("R8 past device", 0, 32'h6010_0000, 0, 2'b11, 0);
        acc("R8 top word", 1, 32'h6C0F_FFFE, 16'h4242, 2'b11, 0);
        acc("R8 top word rd", 0, 32'h6C0F_FFFE, 0, 2'b11, 0);
        // R9 valid held through access
        cfg_addset = 3; cfg_datast = 2;
        acc("R9 held write", 1, ha(1, 20), 16'h9999, 2'b11, 1);
        acc("R9 held read", 0, ha(1, 20), 0, 2'b11, 1);
        @(negedge clk);
        cmp("R9 idle end", idle_ctl(), 0, 0, 0, 0, 0, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule